// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits in a transport-stream datapath and removes unwanted packets. It serves two independent byte streams, each with its own 8192-bit enable bitmap (1024 bytes, one bit per 13-bit PID). For each 188-byte packet it takes the PID from the second and third bytes and looks up that PID's bit. A set bit drops the whole packet and a clear bit forwards it. PIDs below 0x20 always pass, whatever their bits hold.

Software reaches both bitmaps a byte at a time through an indirect window made of two index registers and one data register. Single bits are changed by read-modify-write. Each stream is handled by a four-state machine:

- `ST_HUNT` waits for a start.
- `ST_HDR1` takes PID[12:8].
- `ST_HDR2` takes PID[7:0] and makes the decision.
- `ST_BODY` counts the remaining bytes.

The transitions are:

- START: any state goes to `ST_HDR1` on a flagged 0x47.
- HDR_STEP: `ST_HDR1` goes to `ST_HDR2`.
- DECIDE: `ST_HDR2` goes to `ST_BODY`.
- ABORT: any state goes to `ST_HUNT` on a flagged byte other than 0x47.
- END: `ST_BODY` goes to `ST_HUNT` after byte 187.

Bytes pass through a three-beat delay line so that a packet's first bytes can wait for its decision.

Top module: `ts_pid_gate`

## Requirements
- R1: After reset every bitmap byte is 0, so all PIDs pass. `m_valid` is 0 and `host_rdata` is 0.
- R2: Offset 0x8 holds the byte index low part, PID[10:3]. Offset 0x9 holds PID[12:11] in bits [1:0] and the filter select in bit 2. Reading 0x9 returns those three bits with bits [7:3] as 0.
- R3: Offset 0xA reads or writes bitmap byte {0x9[1:0], 0x8} of the filter chosen by 0x9 bit 2. Read data appears on `host_rdata` one cycle after the read strobe and holds until the next read. A read of any other offset returns 0.
- R4: A packet begins with a byte of 0x47 that has `s_sop` set. Its PID is {byte1[4:0], byte2}. The looked-up bit is bit PID[2:0] of bitmap byte PID[12:3]. A 1 drops all 188 bytes of the packet and a 0 forwards all of them.
- R5: PIDs 0x00 to 0x1F are forwarded even when their bitmap bits are 1.
- R6: Every input beat registers one output step on the same clock edge. That step carries the byte that entered three beats earlier. `m_sop` marks byte 0 of a forwarded packet.
- R7: No byte is forwarded from outside a packet: before a valid start, after byte 187, or after a flagged non-0x47 byte, which ends the current packet.
- R8: A packet cut short by a flagged byte before its third byte arrives is dropped completely.
- R9: Each stream looks up only its own bitmap. The filter select bit steers host access to one bitmap only.
- R10: A host write that lands in the same cycle as a packet's third byte does not change that packet's decision. It applies from the next packet onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| s_valid | input | NUM_FILT | Input byte valid, one bit per stream |
| s_sop | input | NUM_FILT | Packet-start flag per stream |
| s_data | input | NUM_FILT*8 | Input bytes, stream f at [8f+7:8f] |
| m_valid | output | NUM_FILT | Output byte valid per stream |
| m_sop | output | NUM_FILT | First byte of a forwarded packet |
| m_data | output | NUM_FILT*8 | Output bytes, same packing as `s_data` |

## Verification
Streams are driven with whole packets whose PIDs are chosen against a prepared bitmap:

- Pairs of neighbouring PIDs in one byte show that the correct bit is picked.
- A PID set to drop on one stream and pass on the other separates the two bitmaps.
- PIDs 0x1F and 0x20 bracket the always-pass range.

Malformed input is also driven: stray unflagged bytes, a flagged non-sync byte, and a start cut off after two bytes. These show that only framed packets leave the block. A host write timed onto the third byte of a packet, followed by the same PID again, shows which packet the new bit first governs. A behavioural model compares every output and every read on every clock.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    localparam int         PKT_BYTES   = 188;
    localparam logic [7:0] SYNC_BYTE   = 8'h47;
    localparam int         PID_W       = 13;
    localparam logic [PID_W-1:0] PID_FREE_LIMIT = 13'h020;
    localparam logic [3:0] REG_IDX_LO  = 4'h8;
    localparam logic [3:0] REG_IDX_HI  = 4'h9;
    localparam logic [3:0] REG_BYTE    = 4'hA;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HDR1,
        ST_HDR2,
        ST_BODY
    } pkt_state_e;

    typedef struct packed {
        logic       in_pkt;
        logic       start;
        logic [7:0] data;
    } dl_entry_t;
endpackage

// File: rtl/tpg_bitmap.sv
module tpg_bitmap #(
    parameter int BYTES = 1024,
    localparam int IDX_W = $clog2(BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [7:0]       host_wbyte,
    output logic [7:0]       host_rbyte,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [7:0]       lk_byte
);
    logic [7:0] mem_q [BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem_q[i] <= '0;
        end else if (host_we) begin
            mem_q[host_idx] <= host_wbyte;
        end
    end

    // Lookup sees the stored value before any write landing on the same edge.
    assign lk_byte    = mem_q[lk_idx];
    assign host_rbyte = mem_q[host_idx];

    // R3: a written byte is visible at the same index on the next cycle
    assert_wr_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> ((host_idx != $past(host_idx)) || (host_rbyte == $past(host_wbyte))));
endmodule

// File: rtl/tpg_host_regs.sv
module tpg_host_regs
    import tpg_pkg::*;
#(
    parameter int NUM_FILT = 2,
    parameter int IDX_W    = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  we,
    input  logic [3:0]            addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic [NUM_FILT-1:0]   bm_we,
    output logic [IDX_W-1:0]      bm_idx,
    output logic [7:0]            bm_wbyte,
    input  logic [NUM_FILT*8-1:0] bm_rbyte
);
    logic [7:0] idx_lo_q;
    logic [2:0] idx_hi_q;
    logic       fsel;

    assign fsel     = idx_hi_q[2];
    assign bm_idx   = {idx_hi_q[1:0], idx_lo_q};
    assign bm_wbyte = wdata;

    for (genvar f = 0; f < NUM_FILT; f++) begin : g_we
        assign bm_we[f] = sel && we && (addr == REG_BYTE) && (32'(fsel) == f);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_lo_q <= '0;
            idx_hi_q <= '0;
        end else if (sel && we) begin
            if (addr == REG_IDX_LO) idx_lo_q <= wdata;
            if (addr == REG_IDX_HI) idx_hi_q <= wdata[2:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (sel && !we) begin
            unique case (addr)
                REG_IDX_LO: rdata <= idx_lo_q;
                REG_IDX_HI: rdata <= {5'b0, idx_hi_q};
                REG_BYTE:   rdata <= bm_rbyte[32'(fsel)*8 +: 8];
                default:    rdata <= '0;
            endcase
        end
    end

    // R3: read data holds while no read is issued
    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !we) |=> $stable(rdata));
    // R2: upper bits of the high index register read as zero
    assert_hi_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !we && addr == REG_IDX_HI) |=> (rdata[7:3] == 5'b0));
endmodule

// File: rtl/tpg_stream.sv
module tpg_stream
    import tpg_pkg::*;
#(
    parameter int IDX_W = PID_W - 3,
    parameter int DLY   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    output logic [IDX_W-1:0] lk_idx,
    input  logic [7:0]       lk_byte,
    output logic             out_valid,
    output logic             out_sop,
    output logic [7:0]       out_data
);
    localparam int CNT_W = $clog2(PKT_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_BYTES - 1);

    pkt_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [4:0]       pid_hi_q;
    logic             pend_keep_q, pend_keep_d;
    logic             emit_keep_q;
    dl_entry_t        dl_q [DLY];
    dl_entry_t        ent, tail;
    logic             is_start, pid_pass, keep_now;
    logic [PID_W-1:0] pid;

    assign is_start = in_sop && (in_data == SYNC_BYTE);
    assign pid      = {pid_hi_q, in_data};
    assign lk_idx   = pid[PID_W-1:3];
    assign pid_pass = (pid < PID_FREE_LIMIT) || !lk_byte[pid[2:0]];

    // next state and the entry pushed into the delay line
    always_comb begin
        st_d        = st_q;
        cnt_d       = cnt_q;
        pend_keep_d = pend_keep_q;
        ent         = '0;
        ent.data    = in_data;
        if (in_valid) begin
            if (is_start) begin
                st_d        = ST_HDR1;
                cnt_d       = CNT_W'(1);
                pend_keep_d = 1'b0;
                ent.in_pkt  = 1'b1;
                ent.start   = 1'b1;
            end else if (in_sop) begin
                st_d = ST_HUNT;
            end else begin
                unique case (st_q)
                    ST_HUNT: ;
                    ST_HDR1: begin
                        st_d       = ST_HDR2;
                        cnt_d      = CNT_W'(2);
                        ent.in_pkt = 1'b1;
                    end
                    ST_HDR2: begin
                        st_d        = ST_BODY;
                        cnt_d       = CNT_W'(3);
                        pend_keep_d = pid_pass;
                        ent.in_pkt  = 1'b1;
                    end
                    ST_BODY: begin
                        cnt_d      = cnt_q + 1'b1;
                        ent.in_pkt = 1'b1;
                        if (cnt_q == LAST_IDX) st_d = ST_HUNT;
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_HUNT;
            cnt_q       <= '0;
            pid_hi_q    <= '0;
            pend_keep_q <= 1'b0;
        end else begin
            st_q        <= st_d;
            cnt_q       <= cnt_d;
            pend_keep_q <= pend_keep_d;
            if (in_valid && !in_sop && st_q == ST_HDR1) pid_hi_q <= in_data[4:0];
        end
    end

    assign tail     = dl_q[DLY-1];
    assign keep_now = tail.start ? pend_keep_q : emit_keep_q;

    // outputs: delay line and registered output byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DLY; i++) dl_q[i] <= '0;
            emit_keep_q <= 1'b0;
            out_valid   <= 1'b0;
            out_sop     <= 1'b0;
            out_data    <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            if (in_valid) begin
                dl_q[0] <= ent;
                for (int i = 1; i < DLY; i++) dl_q[i] <= dl_q[i-1];
                if (tail.start) emit_keep_q <= pend_keep_q;
                out_valid <= tail.in_pkt && keep_now;
                out_sop   <= tail.start && keep_now;
                out_data  <= tail.data;
            end
        end
    end

    // R4: first header byte is always followed by the second
    assert_hdr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HDR1 && in_valid && !in_sop) |=> (st_q == ST_HDR2));
    // R7: the body count stays inside one packet
    assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BODY) |-> (cnt_q >= CNT_W'(3) && cnt_q <= LAST_IDX));
    // R6: an output byte only follows an input beat
    assert_out_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R6: a forwarded packet start carries the sync byte
    assert_sop_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> (out_data == SYNC_BYTE));
endmodule

// File: rtl/ts_pid_gate.sv
module ts_pid_gate
    import tpg_pkg::*;
#(
    parameter int NUM_FILT = 2,
    parameter int BM_BYTES = 1024,
    localparam int IDX_W   = $clog2(BM_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_sel,
    input  logic                  host_we,
    input  logic [3:0]            host_addr,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    input  logic [NUM_FILT-1:0]   s_valid,
    input  logic [NUM_FILT-1:0]   s_sop,
    input  logic [NUM_FILT*8-1:0] s_data,
    output logic [NUM_FILT-1:0]   m_valid,
    output logic [NUM_FILT-1:0]   m_sop,
    output logic [NUM_FILT*8-1:0] m_data
);
    logic [NUM_FILT-1:0]   bm_we;
    logic [IDX_W-1:0]      bm_idx;
    logic [7:0]            bm_wbyte;
    logic [NUM_FILT*8-1:0] bm_rbyte;

    tpg_host_regs #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (host_sel),
        .we       (host_we),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .rdata    (host_rdata),
        .bm_we    (bm_we),
        .bm_idx   (bm_idx),
        .bm_wbyte (bm_wbyte),
        .bm_rbyte (bm_rbyte)
    );

    for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
        logic [IDX_W-1:0] lk_idx;
        logic [7:0]       lk_byte;

        tpg_bitmap #(.BYTES(BM_BYTES)) u_bm (
            .clk        (clk),
            .rst_n      (rst_n),
            .host_we    (bm_we[f]),
            .host_idx   (bm_idx),
            .host_wbyte (bm_wbyte),
            .host_rbyte (bm_rbyte[f*8 +: 8]),
            .lk_idx     (lk_idx),
            .lk_byte    (lk_byte)
        );

        tpg_stream #(.IDX_W(IDX_W)) u_st (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (s_valid[f]),
            .in_sop    (s_sop[f]),
            .in_data   (s_data[f*8 +: 8]),
            .lk_idx    (lk_idx),
            .lk_byte   (lk_byte),
            .out_valid (m_valid[f]),
            .out_sop   (m_sop[f]),
            .out_data  (m_data[f*8 +: 8])
        );
    end
endmodule

// File: tb/ts_pid_gate_tb_top.sv
module ts_pid_gate_tb_top;
    localparam int NF = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_sel = 1'b0, host_we = 1'b0;
    logic [3:0]    host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;
    logic [NF-1:0] s_valid = '0, s_sop = '0;
    logic [NF*8-1:0] s_data = '0;
    logic [NF-1:0] m_valid, m_sop;
    logic [NF*8-1:0] m_data;

    always #2 clk = ~clk;   // 250 MHz

    ts_pid_gate dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .s_valid(s_valid), .s_sop(s_sop), .s_data(s_data),
        .m_valid(m_valid), .m_sop(m_sop), .m_data(m_data)
    );

    int    total = 0, bad = 0;
    string cur_req = "R1";
    bit    model_on = 0;

    // ---------------- behavioural reference model ----------------
    int bm [2][1024];
    int mst [2];     // 0 hunt, 1 wait byte1, 2 wait byte2, 3 body
    int mcnt [2];
    int mhi [2];
    int mpend [2];
    int memit [2];
    int dq [2][$];   // entry = in_pkt*512 + start*256 + data
    int exp_v [2], exp_s [2], exp_d [2];
    int exp_rd = 0;
    int m_lo = 0, m_hi = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < 2; f++) begin
                for (int i = 0; i < 1024; i++) bm[f][i] = 0;
                mst[f] = 0; mcnt[f] = 0; mhi[f] = 0; mpend[f] = 0; memit[f] = 0;
                dq[f].delete();
                repeat (3) dq[f].push_back(0);
                exp_v[f] = 0; exp_s[f] = 0; exp_d[f] = 0;
            end
            exp_rd = 0; m_lo = 0; m_hi = 0;
        end else begin
            for (int f = 0; f < 2; f++) begin
                exp_v[f] = 0; exp_s[f] = 0;
                if (s_valid[f]) begin
                    int d, e, t, keep, st, pid, pass;
                    d = int'(s_data[f*8 +: 8]);
                    t = dq[f].pop_front();
                    st = (t >> 8) & 1;
                    keep = st ? mpend[f] : memit[f];
                    if (st) memit[f] = mpend[f];
                    exp_v[f] = ((t >> 9) & 1) && keep;
                    exp_s[f] = st && keep;
                    exp_d[f] = t & 255;
                    e = 0;
                    if (s_sop[f] && d == 'h47) begin
                        mst[f] = 1; mpend[f] = 0; e = 512 + 256 + d;
                    end else if (s_sop[f]) begin
                        mst[f] = 0; e = d;
                    end else if (mst[f] == 1) begin
                        mhi[f] = d & 31; mst[f] = 2; e = 512 + d;
                    end else if (mst[f] == 2) begin
                        pid = mhi[f] * 256 + d;
                        pass = (pid < 32) || (((bm[f][pid / 8] >> (pid % 8)) & 1) == 0);
                        mpend[f] = pass; mst[f] = 3; mcnt[f] = 3; e = 512 + d;
                    end else if (mst[f] == 3) begin
                        e = 512 + d;
                        if (mcnt[f] == 187) mst[f] = 0;
                        mcnt[f]++;
                    end else begin
                        e = d;
                    end
                    dq[f].push_back(e);
                end
            end
            if (host_sel) begin
                if (host_we) begin
                    if (host_addr == 4'h8) m_lo = int'(host_wdata);
                    else if (host_addr == 4'h9) m_hi = int'(host_wdata) & 7;
                    else if (host_addr == 4'hA) bm[m_hi >> 2][(m_hi & 3) * 256 + m_lo] = int'(host_wdata);
                end else begin
                    if (host_addr == 4'h8) exp_rd = m_lo;
                    else if (host_addr == 4'h9) exp_rd = m_hi;
                    else if (host_addr == 4'hA) exp_rd = bm[m_hi >> 2][(m_hi & 3) * 256 + m_lo];
                    else exp_rd = 0;
                end
            end
        end
    end

    // ---------------- per-cycle comparison and observation ----------------
    int obs_pk [2], obs_by [2];
    initial begin obs_pk = '{0, 0}; obs_by = '{0, 0}; end

    always @(negedge clk) begin
        if (model_on) begin
            for (int f = 0; f < 2; f++) begin
                total++;
                if (int'(m_valid[f]) != exp_v[f] ||
                    (exp_v[f] != 0 && (int'(m_sop[f]) != exp_s[f] || int'(m_data[f*8 +: 8]) != exp_d[f]))) begin
                    bad++;
                    $display("FAIL %s stream %0d: actual v=%0d s=%0d d=%02h expected v=%0d s=%0d d=%02h",
                             cur_req, f, m_valid[f], m_sop[f], m_data[f*8 +: 8], exp_v[f], exp_s[f], exp_d[f]);
                end
                if (m_valid[f]) begin
                    obs_by[f]++;
                    if (m_sop[f]) obs_pk[f]++;
                end
            end
            total++;
            if (int'(host_rdata) != exp_rd) begin
                bad++;
                $display("FAIL %s host_rdata: actual %02h expected %02h", cur_req, host_rdata, exp_rd);
            end
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(bit ok, string req, int act, int expv, string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic host(bit we, logic [3:0] a, logic [7:0] wd);
        host_sel = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_rd(logic [3:0] a, int expv, string req);
        host(1'b0, a, 8'h00);
        check(int'(host_rdata) == expv, req, int'(host_rdata), expv, "register read");
    endtask

    task automatic beat(int f, bit sop, logic [7:0] d);
        s_valid[f] = 1'b1; s_sop[f] = sop; s_data[f*8 +: 8] = d;
        @(negedge clk);
        s_valid[f] = 1'b0; s_sop[f] = 1'b0;
    endtask

    task automatic send_pkt(int f, int pid, int wr_at, logic [7:0] wr_val);
        for (int i = 0; i < 188; i++) begin
            logic [7:0] d;
            if (i == 0) d = 8'h47;
            else if (i == 1) d = 8'((pid >> 8) & 31);
            else if (i == 2) d = 8'(pid & 255);
            else d = 8'(i * 13 + pid);
            if (i == wr_at) begin
                host_sel = 1'b1; host_we = 1'b1; host_addr = 4'hA; host_wdata = wr_val;
            end
            beat(f, i == 0, d);
            host_sel = 1'b0; host_we = 1'b0;
        end
    endtask

    task automatic pads(int f, int n);
        for (int i = 0; i < n; i++) beat(f, 1'b0, 8'(8'h47 + i));
    endtask

    task automatic expect_delta(int f, int p0, int b0, int np, string req);
        @(negedge clk);
        check(obs_pk[f] - p0 == np, req, obs_pk[f] - p0, np, "forwarded packets");
        check(obs_by[f] - b0 == 188 * np, req, obs_by[f] - b0, 188 * np, "forwarded bytes");
    endtask

    task automatic run_pkt(int f, int pid, int np, string req);
        int p0, b0;
        p0 = obs_pk[f]; b0 = obs_by[f];
        send_pkt(f, pid, -1, 8'h00);
        pads(f, 4);
        expect_delta(f, p0, b0, np, req);
    endtask

    task automatic set_idx(int filt, int idx);
        host(1'b1, 4'h8, 8'(idx & 255));
        host(1'b1, 4'h9, 8'(((idx >> 8) & 3) | (filt << 2)));
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;
        cur_req = "R1";
        check(host_rdata == 8'h00, "R1", int'(host_rdata), 0, "rdata after reset");
        check(m_valid == '0, "R1", int'(m_valid), 0, "m_valid after reset");
        run_pkt(0, 'h100, 1, "R1");
        run_pkt(1, 'h1FFF, 1, "R1");

        cur_req = "R2";
        host(1'b1, 4'h8, 8'hA5);
        host(1'b1, 4'h9, 8'hFF);
        host_rd(4'h8, 'hA5, "R2");
        host_rd(4'h9, 'h07, "R2");

        cur_req = "R3";
        host(1'b1, 4'hA, 8'h3C);
        host_rd(4'hA, 'h3C, "R3");
        host_rd(4'h3, 'h00, "R3");
        repeat (3) @(negedge clk);
        check(host_rdata == 8'h00, "R3", int'(host_rdata), 0, "rdata hold");
        cur_req = "R9";
        host(1'b1, 4'h9, 8'h03);
        host_rd(4'hA, 'h00, "R9");

        cur_req = "R4";
        set_idx(0, 'h123 >> 3);
        host_rd(4'hA, 'h00, "R4");
        host(1'b1, 4'hA, 8'h08);          // bit 3 -> PID 0x123 drops
        run_pkt(0, 'h123, 0, "R4");
        run_pkt(0, 'h122, 1, "R4");
        cur_req = "R9";
        run_pkt(1, 'h123, 1, "R9");
        run_pkt(1, 'h1D2A, 0, "R9");      // filter 1 byte 0x3A5 = 0x3C
        run_pkt(0, 'h1D2A, 1, "R9");

        cur_req = "R5";
        set_idx(0, 0); host(1'b1, 4'hA, 8'hFF);
        set_idx(0, 3); host(1'b1, 4'hA, 8'hFF);
        set_idx(0, 4); host(1'b1, 4'hA, 8'hFF);
        run_pkt(0, 'h000, 1, "R5");
        run_pkt(0, 'h01F, 1, "R5");
        run_pkt(0, 'h020, 0, "R5");

        cur_req = "R7";
        begin
            int p0, b0;
            p0 = obs_pk[0]; b0 = obs_by[0];
            pads(0, 10);
            beat(0, 1'b1, 8'h00);
            pads(0, 6);
            expect_delta(0, p0, b0, 0, "R7");
        end

        cur_req = "R8";
        begin
            int p0, b0;
            p0 = obs_pk[0]; b0 = obs_by[0];
            beat(0, 1'b1, 8'h47);
            beat(0, 1'b0, 8'h01);
            send_pkt(0, 'h155, -1, 8'h00);
            pads(0, 4);
            expect_delta(0, p0, b0, 1, "R8");
        end

        cur_req = "R10";
        set_idx(0, 'h200 >> 3);
        begin
            int p0, b0;
            p0 = obs_pk[0]; b0 = obs_by[0];
            send_pkt(0, 'h200, 2, 8'h01);
            pads(0, 4);
            expect_delta(0, p0, b0, 1, "R10");
        end
        run_pkt(0, 'h200, 0, "R10");

        cur_req = "R6";
        run_pkt(1, 'h0ABC, 1, "R6");

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule